// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block is a real-time clock register block on a byte-wide register bus. It keeps a 32-bit count of elapsed seconds and a 32-bit alarm value. Each of the two values is exposed as four byte registers, with the most significant byte at the lowest address. A fast tick input runs through a prescaler, and the prescaler advances the counter once per second. The bus front end (for example an SMBus or I2C target) lies outside the block. That front end turns each transaction into a single one-cycle read or write strobe.

The host moves one byte per transaction. To set the time, it writes the upper bytes first; these only load a staging register. Writing the least significant byte then loads the whole staged value into the counter and restarts the prescaler phase. To read the time, the host reads the most significant byte first. That read takes a snapshot of the full count, and the three lower byte addresses return bytes of that snapshot, so a second boundary between reads cannot tear the value.

An alarm fires when the count equals the alarm value. The value with every bit set means the alarm is off; no separate enable bit exists. Each match produces exactly one event pulse. The event sets a sticky flag in an interrupt source register. Two control bits decide whether the event also pulses a wake-from-sleep request, a power-up-from-shutdown request, or both.

Top module: `rtc_seconds_alarm`

## Requirements
- R1: After reset the counter is 0, the alarm value is 0xFFFFFFFF, the control register and the alarm flag are 0, and every pulse output is low.
- R2: The counter increases by one after each TICKS_PER_SEC cycles in which tick_i is high. It wraps from 0xFFFFFFFF to 0.
- R3: Time bytes live at 0x70 (bits 31:24) through 0x73 (bits 7:0). Writes to 0x70..0x72 only stage a byte and leave the counter unchanged. A write to 0x73 loads the counter with the three staged bytes above the written byte.
- R4: A write to 0x73 restarts the prescaler, so the next increment needs a full TICKS_PER_SEC further ticks.
- R5: A read of 0x70 returns bits 31:24 of the live count and captures the whole count. Reads of 0x71..0x73 return bits 23:16, 15:8 and 7:0 of that captured value.
- R6: Alarm bytes live at 0x74 (bits 31:24) through 0x77 (bits 7:0). Each write takes effect at once, and each byte reads back what was written.
- R7: alarm_evt_o is high for exactly one cycle when the count becomes equal to the alarm value. It does not pulse again while the two stay equal.
- R8: An alarm value of 0xFFFFFFFF produces no event, including when the counter holds 0xFFFFFFFF.
- R9: Register 0x10 bit 3 is a sticky alarm flag, and irq_o follows it. Writing 1 to bit 3 clears the flag, but an event in the same cycle keeps it set. All other bits read 0.
- R10: Register 0x29 holds the wake enable in bit 3 and the power-up enable in bit 2. All other bits read 0.
- R11: wake_req_o pulses together with an alarm event while bit 3 of 0x29 is set. powerup_req_o pulses together with an alarm event while bit 2 is set.
- R12: Read data appears on rdata_o in the cycle after the read strobe. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick enable |
| we_i | input | 1 | Single-byte write strobe |
| re_i | input | 1 | Single-byte read strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one cycle after re_i |
| alarm_evt_o | output | 1 | One-cycle alarm event |
| irq_o | output | 1 | Sticky alarm flag |
| wake_req_o | output | 1 | Wake-from-sleep request pulse |
| powerup_req_o | output | 1 | Power-up-from-shutdown request pulse |

## Verification
The counter is loaded with several patterns: a mixed-byte value, a value whose low byte is 0xFF, and the wrap value 0xFFFFFFFE. The 0xFF case is read with a second boundary falling between the first and later byte reads; only a snapshot, and not a live read, returns a consistent value there. Partial prescaler phases before a commit show whether the phase restarts on commit. The alarm is tried with the wake bit only, the power-up bit only, a long dwell on a match, and the all-ones value reached by the counter. Together these separate the edge detection, the disable encoding, and the routing of each enable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NBYTES      = 4;
  localparam logic [7:0]  TIME_BASE   = 8'h70;
  localparam logic [7:0]  ALARM_BASE  = 8'h74;
  localparam logic [7:0]  STATUS_ADDR = 8'h10;
  localparam logic [7:0]  CTRL_ADDR   = 8'h29;
  localparam int unsigned ALARM_BIT   = 3;
  localparam int unsigned WAKE_BIT    = 3;
  localparam int unsigned PWRUP_BIT   = 2;

  typedef struct packed {
    logic wake_en;
    logic pwrup_en;
  } rtc_ctrl_t;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic sec_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV > 1) begin : g_div
      logic [PW-1:0] phase_q;
      logic          last;
      assign last  = (phase_q == PW'(DIV - 1));
      assign sec_o = tick_i && last && !clr_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     phase_q <= '0;
        else if (clr_i)  phase_q <= '0;
        else if (tick_i) phase_q <= last ? '0 : phase_q + 1'b1;
      end

      // R4: restart leaves phase at zero
      a_r4_phase_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (phase_q == '0));
    end else begin : g_pass
      assign sec_o = tick_i && !clr_i;
    end
  endgenerate
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned NBYTES = rtc_pkg::NBYTES,
  localparam int unsigned W  = NBYTES * 8,
  localparam int unsigned IW = $clog2(NBYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sec_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    wdata_i,
  output logic [W-1:0]  cnt_o,
  output logic [7:0]    rbyte_o,
  output logic          commit_o
);
  logic [W-1:0] cnt_q, snap_q, load_val;
  logic [7:0]   stage_q [NBYTES-1];
  logic         last_idx, first_idx;

  assign last_idx  = (idx_i == IW'(NBYTES - 1));
  assign first_idx = (idx_i == '0);
  assign commit_o  = wr_i && last_idx;

  generate
    for (genvar k = 0; k < NBYTES - 1; k++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          stage_q[k] <= '0;
        else if (wr_i && idx_i == IW'(k))     stage_q[k] <= wdata_i;
      end
    end
  endgenerate

  always_comb begin
    load_val      = '0;
    load_val[7:0] = wdata_i;
    for (int k = 0; k < NBYTES - 1; k++)
      load_val[(NBYTES-1-k)*8 +: 8] = stage_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (commit_o) cnt_q <= load_val;
    else if (sec_i)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                snap_q <= '0;
    else if (rd_i && first_idx) snap_q <= cnt_q;
  end

  assign rbyte_o = first_idx ? cnt_q[W-1 -: 8] : snap_q[(NBYTES-1-idx_i)*8 +: 8];
  assign cnt_o   = cnt_q;

  // R2: count holds without a second pulse or a commit
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_i && !commit_o) |=> $stable(cnt_q));
  // R2: one step per second pulse
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_i && !commit_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R3: commit low byte comes from the bus
  a_r3_commit_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (cnt_q[7:0] == $past(wdata_i)));
  // R5: snapshot follows the live count on an MSB read
  a_r5_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && first_idx) |=> (snap_q == $past(cnt_q)));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned NBYTES = rtc_pkg::NBYTES,
  localparam int unsigned W  = NBYTES * 8,
  localparam int unsigned IW = $clog2(NBYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    wdata_i,
  input  logic [W-1:0]  cnt_i,
  output logic [7:0]    rbyte_o,
  output logic          evt_o
);
  logic [W-1:0] alarm_q;
  logic         armed, match, match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   alarm_q <= '1;
    else if (wr_i) alarm_q[(NBYTES-1-idx_i)*8 +: 8] <= wdata_i;
  end

  assign armed = (alarm_q != '1);
  assign match = armed && (cnt_i == alarm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= match;
  end

  assign evt_o   = match && !match_q;
  assign rbyte_o = alarm_q[(NBYTES-1-idx_i)*8 +: 8];

  // R7: never two events back to back
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
  // R8: all-ones alarm never fires
  a_r8_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_q == '1) |-> !evt_o);
  // R7: event only on equality
  a_r7_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (cnt_i == alarm_q));
endmodule

// File: rtl/rtc_seconds_alarm.sv
module rtc_seconds_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned NUM_BYTES     = rtc_pkg::NBYTES
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       alarm_evt_o,
  output logic       irq_o,
  output logic       wake_req_o,
  output logic       powerup_req_o
);
  localparam int unsigned W  = NUM_BYTES * 8;
  localparam int unsigned IW = $clog2(NUM_BYTES);

  logic [7:0]    t_off, a_off;
  logic          t_hit, a_hit, st_hit, ct_hit;
  logic [IW-1:0] t_idx, a_idx;
  logic [W-1:0]  cnt;
  logic [7:0]    t_byte, a_byte, rd_mux, rdata_q;
  logic          sec, commit, evt, flag_q;
  rtc_ctrl_t     ctrl_q;

  assign t_off  = addr_i - TIME_BASE;
  assign a_off  = addr_i - ALARM_BASE;
  assign t_hit  = (t_off < 8'(NUM_BYTES));
  assign a_hit  = (a_off < 8'(NUM_BYTES));
  assign st_hit = (addr_i == STATUS_ADDR);
  assign ct_hit = (addr_i == CTRL_ADDR);
  assign t_idx  = t_off[IW-1:0];
  assign a_idx  = a_off[IW-1:0];

  rtc_tick_div #(.DIV(TICKS_PER_SEC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .clr_i  (commit),
    .sec_o  (sec)
  );

  rtc_sec_counter #(.NBYTES(NUM_BYTES)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sec_i    (sec),
    .wr_i     (we_i && t_hit),
    .rd_i     (re_i && t_hit),
    .idx_i    (t_idx),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt),
    .rbyte_o  (t_byte),
    .commit_o (commit)
  );

  rtc_alarm_cmp #(.NBYTES(NUM_BYTES)) u_alm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && a_hit),
    .idx_i   (a_idx),
    .wdata_i (wdata_i),
    .cnt_i   (cnt),
    .rbyte_o (a_byte),
    .evt_o   (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ctrl_q <= '0;
    else if (we_i && ct_hit)  ctrl_q <= '{wake_en: wdata_i[WAKE_BIT], pwrup_en: wdata_i[PWRUP_BIT]};
  end

  // event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= evt || (flag_q && !(we_i && st_hit && wdata_i[ALARM_BIT]));
  end

  always_comb begin
    rd_mux = '0;
    if (t_hit)       rd_mux = t_byte;
    else if (a_hit)  rd_mux = a_byte;
    else if (st_hit) rd_mux[ALARM_BIT] = flag_q;
    else if (ct_hit) begin
      rd_mux[WAKE_BIT]  = ctrl_q.wake_en;
      rd_mux[PWRUP_BIT] = ctrl_q.pwrup_en;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o       = rdata_q;
  assign alarm_evt_o   = evt;
  assign irq_o         = flag_q;
  assign wake_req_o    = evt && ctrl_q.wake_en;
  assign powerup_req_o = evt && ctrl_q.pwrup_en;

  // R9: event sets the flag
  a_r9_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_evt_o |=> irq_o);
  // R9: flag only rises from an event
  a_r9_flag_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(alarm_evt_o));
  // R11: requests only with an event
  a_r11_wake_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> alarm_evt_o);
  a_r11_pwrup_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    powerup_req_o |-> alarm_evt_o);
  // R12: read data stable without a strobe
  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_rtc_seconds_alarm.sv
module tb_rtc_seconds_alarm;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic evt, irq, wake, pwrup;

  always #5 clk = ~clk;

  rtc_seconds_alarm #(.TICKS_PER_SEC(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .alarm_evt_o(evt),
    .irq_o(irq), .wake_req_o(wake), .powerup_req_o(pwrup)
  );

  int n_chk = 0, n_fail = 0;
  int n_evt = 0, n_wake = 0, n_pwr = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected byte per completed read
  always @(posedge clk) rd_seen <= re;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check(rdata, 8'hxx, "R12 unexpected read");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
    if (rst_n) begin
      if (evt)   n_evt++;
      if (wake)  n_wake++;
      if (pwrup) n_pwr++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic raw_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic secs(input int n);
    raw_ticks(n * DIV);
  endtask

  task automatic set_time(input logic [31:0] v);
    for (int k = 0; k < 4; k++) wr(8'h70 + 8'(k), v[(3-k)*8 +: 8]);
  endtask

  task automatic set_alarm(input logic [31:0] v);
    for (int k = 0; k < 4; k++) wr(8'h74 + 8'(k), v[(3-k)*8 +: 8]);
  endtask

  task automatic read_time(input logic [31:0] v, input string tag);
    for (int k = 0; k < 4; k++) rd(8'h70 + 8'(k), v[(3-k)*8 +: 8], tag);
  endtask

  task automatic drain();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({evt, irq, wake, pwrup}, 4'b0, "R1 outputs after reset");
    read_time(32'h0, "R1 counter reset");
    for (int k = 0; k < 4; k++) rd(8'h74 + 8'(k), 8'hFF, "R1 alarm reset");
    rd(8'h29, 8'h00, "R1 control reset");
    rd(8'h10, 8'h00, "R1 flag reset");

    // R3 staging without effect
    wr(8'h70, 8'h12); wr(8'h71, 8'h34); wr(8'h72, 8'h56);
    read_time(32'h0, "R3 staged bytes do not load");
    wr(8'h73, 8'h78);
    read_time(32'h12345678, "R3 commit on LSB");

    // R2 counting
    secs(3);
    read_time(32'h1234567B, "R2 three seconds");

    // R4 prescaler restart
    raw_ticks(2);
    set_time(32'h00000010);
    raw_ticks(DIV - 1);
    read_time(32'h00000010, "R4 no step before full period");
    raw_ticks(1);
    read_time(32'h00000011, "R4 step after full period");

    // R5 snapshot coherence across a carry
    set_time(32'h000000FF);
    rd(8'h70, 8'h00, "R5 MSB live");
    secs(1);
    rd(8'h71, 8'h00, "R5 snapshot byte2");
    rd(8'h72, 8'h00, "R5 snapshot byte1");
    rd(8'h73, 8'hFF, "R5 snapshot byte0");
    read_time(32'h00000100, "R5 fresh snapshot");

    // R6 alarm, R7 single pulse, R11 wake only
    wr(8'h29, 8'h08);
    rd(8'h29, 8'h08, "R10 wake bit");
    set_alarm(32'h00000105);
    for (int k = 0; k < 4; k++) rd(8'h74 + 8'(k), (k == 2) ? 8'h01 : (k == 3) ? 8'h05 : 8'h00, "R6 alarm readback");
    secs(4);
    check(n_evt, 0, "R7 no early event");
    secs(1);
    repeat (10) @(negedge clk);
    check(n_evt, 1, "R7 one event on match");
    check(n_wake, 1, "R11 wake pulse");
    check(n_pwr, 0, "R11 no power-up pulse");
    check(irq, 1'b1, "R9 irq set");
    rd(8'h10, 8'h08, "R9 flag readback");
    wr(8'h10, 8'h08);
    check(irq, 1'b0, "R9 irq cleared");
    rd(8'h10, 8'h00, "R9 flag cleared");

    // R8 all-ones disables, R2 wrap
    set_alarm(32'hFFFFFFFF);
    set_time(32'hFFFFFFFE);
    secs(1);
    read_time(32'hFFFFFFFF, "R8 counter at all ones");
    secs(1);
    read_time(32'h00000000, "R2 wrap to zero");
    check(n_evt, 1, "R8 no event when disabled");
    check(irq, 1'b0, "R8 flag untouched");

    // R11 power-up only
    wr(8'h29, 8'h04);
    set_alarm(32'h00000002);
    secs(2);
    @(negedge clk);
    check(n_evt, 2, "R7 second event");
    check(n_pwr, 1, "R11 power-up pulse");
    check(n_wake, 1, "R11 wake stays");

    // R10 reserved bits, R12 unmapped
    wr(8'h29, 8'hFF);
    rd(8'h29, 8'h0C, "R10 reserved bits read zero");
    rd(8'h50, 8'h00, "R12 unmapped reads zero");
    drain();
    check(exp_q.size(), 0, "R12 all reads returned");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule